// File: doc/BRIEF.md
# Signed Serial-by-Fixed-Coefficient Multiplier

This block multiplies a two's complement operand that arrives one bit per clock, least significant bit first, by a signed coefficient fixed at elaboration time. It returns the full-precision product as a bit stream in the same order. The coefficient never changes at run time. Each coefficient bit either routes the serial bit into its stage or routes a constant zero.

The datapath is a chain of one-bit stages, one per coefficient bit. The stage for the coefficient sign bit sits at the input end. It is a serial negation element. Every lower stage is a serial full adder whose carry stays in place while the partial sums move one position toward the output on each clock. The product bit is taken from the registered sum of the lowest stage. A one-cycle `word_start_i` strobe, aligned with each word's least significant bit, discards all carry and negation state left by the previous word. Words can therefore follow each other with no idle cycles. Upstream logic must sign extend the operand to the full word length.

Top module: `serial_coef_mult`

## Requirements
- R1: Operand and product both move least significant bit first, one bit per clock. Product bit t appears on `prod_o` during the clock cycle after operand bit t was presented on `ser_i`.
- R2: The WORD_W product bits of a word equal (COEF × operand) modulo 2^WORD_W, read as two's complement. This holds when the operand is sign extended to WORD_W bits and WORD_W ≥ COEF_W + operand width.
- R3: Negative coefficients, including the most negative COEF_W-bit value, produce the correct signed product. No product bits are added for the coefficient sign.
- R4: The most negative and most positive operand values produce the correct signed product.
- R5: When `word_start_i` is high (the cycle of a word's LSB), that cycle's update ignores all carry state, negation-detect state and partial sums from earlier cycles. After that cycle every carry is 0, and each word's product is independent of the previous word.
- R6: Bits presented on `ser_i` between the end of one word and the next `word_start_i` have no effect on the next word's product.
- R7: The negation stage outputs its input unchanged up to and including the first 1 of a word. After that it outputs the inverse of its input until the next `word_start_i`, and its detect state stays set until then.
- R8: `rst_ni` low asynchronously clears all state, and `prod_o` is 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_start_i | input | 1 | High for one cycle with each word's least significant bit |
| ser_i | input | 1 | Serial operand bit, LSB first, sign extended to WORD_W |
| prod_o | output | 1 | Serial product bit, LSB first, one cycle behind `ser_i` |

## Verification
The bench runs three instances on one stream. One has the most negative coefficient, one a positive coefficient and one an ordinary negative coefficient. It drives the extreme operand values through them, including the case where both operands are most negative. A sign-handling error there corrupts the upper half of the product. Words are sent back to back and also with idle gaps filled with random bits. If a word start failed to clear the stages, carries or a set negation detector would leak into the next word's low bits. If the design treated the gap bits as data, they would appear in the next result. A latency error shifts every captured word by one position, so nearly every comparison fails.

// File: rtl/serial_mult_pkg.sv
package serial_mult_pkg;
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/serial_add_stage.sv
module serial_add_stage
  import serial_mult_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic a_i,
  input  logic b_i,
  output logic s_o,
  output logic c_o
);
  logic b_eff, c_eff;

  // clr drops the stale upstream sum and the stored carry in the LSB cycle
  assign b_eff = b_i & ~clr_i;
  assign c_eff = c_o & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_o <= 1'b0;
      c_o <= 1'b0;
    end else begin
      s_o <= fa_sum(a_i, b_eff, c_eff);
      c_o <= fa_carry(a_i, b_eff, c_eff);
    end
  end
endmodule

// File: rtl/serial_negate_stage.sv
module serial_negate_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic a_i,
  output logic q_o,
  output logic det_o
);
  logic det_eff;

  assign det_eff = det_o & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= 1'b0;
      det_o <= 1'b0;
    end else begin
      q_o   <= a_i ^ det_eff;
      det_o <= det_eff | a_i;
    end
  end
endmodule

// File: rtl/serial_coef_mult.sv
module serial_coef_mult #(
  parameter int                       COEF_W = 8,
  parameter int                       WORD_W = 20,
  parameter logic signed [COEF_W-1:0] COEF   = -8'sd93
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic word_start_i,
  input  logic ser_i,
  output logic prod_o
);
  localparam int TOP = COEF_W - 1;

  if (COEF_W < 2) begin : g_bad_coef
    $error("COEF_W must be at least 2");
  end
  if (WORD_W < COEF_W + 1) begin : g_bad_word
    $error("WORD_W too short for the coefficient width");
  end

  logic [COEF_W-1:0] pp;       // partial product bits, one per stage
  logic [COEF_W-1:0] sum_q;    // registered stage outputs
  logic [COEF_W-2:0] carry_q;  // adder carries
  logic              detect_q; // negation stage first-one flag

  assign pp = COEF_W'(COEF) & {COEF_W{ser_i}};

  // sign bit stage at the serial-input end
  serial_negate_stage i_neg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (word_start_i),
    .a_i   (pp[TOP]),
    .q_o   (sum_q[TOP]),
    .det_o (detect_q)
  );

  for (genvar k = 0; k < TOP; k++) begin : g_add
    serial_add_stage i_add (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (word_start_i),
      .a_i   (pp[k]),
      .b_i   (sum_q[k+1]),
      .s_o   (sum_q[k]),
      .c_o   (carry_q[k])
    );
  end

  assign prod_o = sum_q[0];
endmodule

// File: rtl/serial_coef_mult_chk.sv
module serial_coef_mult_chk #(
  parameter int                       COEF_W = 8,
  parameter logic signed [COEF_W-1:0] COEF   = -8'sd93
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_start_i,
  input logic              ser_i,
  input logic              prod_o,
  input logic [COEF_W-1:0] sum_q,
  input logic [COEF_W-2:0] carry_q,
  input logic              detect_q
);
  logic top_in, low_in;
  assign top_in = ser_i & COEF[COEF_W-1];
  assign low_in = ser_i & COEF[0];

  AST_FIRST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_start_i |=> prod_o == $past(low_in)); // R1

  AST_CARRY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_start_i |=> carry_q == '0); // R5

  AST_DETECT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_start_i |=> detect_q == $past(top_in)); // R5

  AST_DETECT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detect_q && !word_start_i) |=> detect_q); // R7

  AST_NEG_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!detect_q || word_start_i) |=> sum_q[COEF_W-1] == $past(top_in)); // R7

  AST_NEG_INVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detect_q && !word_start_i) |=> sum_q[COEF_W-1] == !$past(top_in)); // R7
endmodule

bind serial_coef_mult serial_coef_mult_chk #(
  .COEF_W(COEF_W),
  .COEF  (COEF)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_start_i(word_start_i),
  .ser_i       (ser_i),
  .prod_o      (prod_o),
  .sum_q       (sum_q),
  .carry_q     (carry_q),
  .detect_q    (detect_q)
);

// File: tb/test_serial_coef_mult.sv
module test_serial_coef_mult;
  localparam int CLK_PERIOD = 10;
  localparam int COEF_W = 8;
  localparam int OPND_W = 12;
  localparam int WORD_W = COEF_W + OPND_W;
  localparam logic signed [COEF_W-1:0] C_MAIN = -8'sd93;
  localparam logic signed [COEF_W-1:0] C_MIN  = 8'sh80;
  localparam logic signed [COEF_W-1:0] C_POS  = 8'sd109;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_start = 1'b0;
  logic ser = 1'b0;
  logic p_main, p_min, p_pos;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [WORD_W-1:0] cap_main, cap_min, cap_pos;
  logic signed [OPND_W-1:0] cur_y;
  string cur_tag;
  bit pending = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_coef_mult #(.COEF_W(COEF_W), .WORD_W(WORD_W), .COEF(C_MAIN)) i_serial_coef_mult (
    .clk_i(clk), .rst_ni(rst_n), .word_start_i(word_start), .ser_i(ser), .prod_o(p_main));
  serial_coef_mult #(.COEF_W(COEF_W), .WORD_W(WORD_W), .COEF(C_MIN)) i_serial_coef_mult_min (
    .clk_i(clk), .rst_ni(rst_n), .word_start_i(word_start), .ser_i(ser), .prod_o(p_min));
  serial_coef_mult #(.COEF_W(COEF_W), .WORD_W(WORD_W), .COEF(C_POS)) i_serial_coef_mult_pos (
    .clk_i(clk), .rst_ni(rst_n), .word_start_i(word_start), .ser_i(ser), .prod_o(p_pos));

  function automatic logic [WORD_W-1:0] exp_prod(input logic signed [OPND_W-1:0] y,
                                                 input logic signed [COEF_W-1:0] c);
    int full;
    full = int'(y) * int'(c);
    return full[WORD_W-1:0];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [WORD_W-1:0] got, input logic [WORD_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s y=%0d got=%h exp=%h", tag, what, cur_y, got, exp);
    end
  endtask

  // capture the last product bit of the pending word and compare
  task automatic finish_prev();
    if (pending) begin
      cap_main[WORD_W-1] = p_main;
      cap_min[WORD_W-1]  = p_min;
      cap_pos[WORD_W-1]  = p_pos;
      check(cur_tag, "coef=-93 (R7)", cap_main, exp_prod(cur_y, C_MAIN));
      check(cur_tag, "coef=min (R3)", cap_min, exp_prod(cur_y, C_MIN));
      check(cur_tag, "coef=+109 (R2)", cap_pos, exp_prod(cur_y, C_POS));
      pending = 1'b0;
    end
  endtask

  // bit t is driven before edge t; product bit t-1 is sampled at that negedge (R1)
  task automatic drive_word(input logic signed [OPND_W-1:0] y, input int gap, input string tag);
    logic signed [WORD_W-1:0] ys;
    ys = y;
    for (int t = 0; t < WORD_W; t++) begin
      @(negedge clk);
      if (t == 0) finish_prev();
      else begin
        cap_main[t-1] = p_main;
        cap_min[t-1]  = p_min;
        cap_pos[t-1]  = p_pos;
      end
      ser = ys[t];
      word_start = (t == 0);
    end
    cur_y = y;
    cur_tag = tag;
    pending = 1'b1;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      finish_prev();
      ser = 1'($urandom);
      word_start = 1'b0;
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    ser = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if ({p_main, p_min, p_pos} !== 3'b000) begin
      errors++;
      $display("FAIL R8 output during reset got=%b exp=000", {p_main, p_min, p_pos});
    end
    ser = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if ({p_main, p_min, p_pos} !== 3'b000) begin
      errors++;
      $display("FAIL R8 idle after reset got=%b exp=000", {p_main, p_min, p_pos});
    end

    // directed corners, back to back
    drive_word(12'sh800, 0, "R4");
    drive_word(12'sh7ff, 0, "R4");
    drive_word(-12'sd1, 0, "R5");
    drive_word(12'sd1, 0, "R5");
    drive_word(12'sd0, 0, "R5");
    drive_word(12'sh800, 0, "R4");
    drive_word(12'sd1, 3, "R1");
    // random gap bits must not leak in
    drive_word(-12'sd1, 2, "R6");
    drive_word(12'sd5, 1, "R6");
    drive_word(-12'sd7, 0, "R6");

    for (int i = 0; i < 300; i++) begin
      drive_word(OPND_W'($urandom), int'($urandom_range(0, 2)), "R2");
    end
    @(negedge clk);
    finish_prev();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got=running exp=finished");
      report();
    end
  end
endmodule